// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface and walks the memory from power-on to a usable state. After synchronous reset it holds the clock-enable and data-mask pins high and issues only no-operation commands for a startup pause. The pause length in clock cycles is the product of a clock-frequency parameter in MHz and a pause-length parameter in microseconds; the defaults give 200 µs at 125 MHz. It then issues a single precharge of all banks, a fixed number of auto-refresh commands and one mode-register load that carries the caller's mode word on the address pins. The refreshes come either before or after the mode load, as a parameter selects. When the last wait has elapsed it raises `init_done` and keeps it high.

Every pin driven toward the memory comes straight from a register. The block has no data stream, so there is no valid/ready pair and no back-pressure. Its only inputs are the clock, the reset and the mode word, and it samples the mode word only on the edge where it issues the mode-load command. Commands are spaced in whole cycles: `T_RP` cycles from the precharge to the next command, `T_RC` from each refresh, and `T_MRD` (at least 2) from the mode load. Each spacing counts the cycle that carries the command.

Top module: `sdram_init_seq`

## Requirements
- R1: With P = CLK_MHZ*PAUSE_US, the block drives only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, address 0) on rising edges 1 to P-1 after reset is released. The first other command appears on edge P.
- R2: cke stays 1 at all times. dqm is 1 from reset until init_done rises, and it falls to 0 on the same edge.
- R3: Exactly one precharge-all is issued, on edge P. It is encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0, with only address bit AP_BIT set and bank 0.
- R4: Exactly N_REF (at least 8) auto-refresh commands are issued, encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with address 0. The command after the precharge comes T_RP edges after it. The command after each refresh comes T_RC edges after it.
- R5: With REF_FIRST=1 all refreshes come before the mode load. With REF_FIRST=0 the mode load follows the precharge and all refreshes follow the mode load.
- R6: The mode load is encoded as cs_n, ras_n, cas_n and we_n all 0, with the address pins equal to mode_word as sampled on that edge. mode_word has no effect on the pins at any other time.
- R7: The mode load is followed by T_MRD-1 NOP cycles (at least one) before the next command or before init_done.
- R8: init_done rises one spacing after the last command of the sequence. After that it stays 1 and only NOP is driven.
- R9: A synchronous reset, at any point, drives NOP, init_done=0, dqm=1 and cke=1, and the whole sequence starts again from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| mode_word | input | ADDR_W | Value placed on the address pins by the mode load |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_dqm | output | 1 | Data mask, high until init_done |
| mem_addr | output | ADDR_W | Address pins |
| mem_ba | output | BA_W | Bank address pins, always 0 |
| init_done | output | 1 | Sequence finished; stays high until reset |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of the refresh train or right after the mode load. The block must drop every count and the remembered phase, yet nothing at the ports shows where it was. The bench therefore drives reset at chosen edge counts inside the refresh train and just after the mode load. A second instance is built with the opposite ordering parameter, so that both orders are compared cycle by cycle against a schedule computed in the bench. The mode word is changed on every cycle so that any sampling outside the mode-load edge would show on the address pins.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Step chosen by the controller on a given edge
  typedef enum logic [2:0] {
    ISS_NONE = 3'd0,
    ISS_PRE  = 3'd1,
    ISS_REF  = 3'd2,
    ISS_MRS  = 3'd3,
    ISS_FIN  = 3'd4
  } issue_e;

  // Next step the controller is waiting to take
  typedef enum logic [2:0] {
    PH_PRE  = 3'd0,
    PH_REF  = 3'd1,
    PH_MRS  = 3'd2,
    PH_FIN  = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t PINS_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  function automatic cmd_pins_t pins_for(issue_e iss);
    case (iss)
      ISS_PRE: return PINS_PRE;
      ISS_REF: return PINS_REF;
      ISS_MRS: return PINS_MRS;
      default: return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W    = 16,
  parameter int INIT_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(INIT_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int N_REF     = 8,
  parameter bit REF_FIRST = 1'b1,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2
) (
  input  logic   clk,
  input  logic   rst,
  output issue_e issue
);

  localparam int MAX_A  = (PAUSE_CYC > T_RP) ? PAUSE_CYC : T_RP;
  localparam int MAX_B  = (T_RC > T_MRD) ? T_RC : T_MRD;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int REF_W  = $clog2(N_REF + 1);

  phase_e           phase_q;
  logic [REF_W-1:0] ref_cnt_q;
  logic             zero;
  logic             load;
  logic [CNT_W-1:0] load_val;

  sdram_init_timer #(
    .CNT_W   (CNT_W),
    .INIT_VAL(PAUSE_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .zero    (zero)
  );

  always_comb begin
    issue = ISS_NONE;
    if (zero) begin
      case (phase_q)
        PH_PRE:  issue = ISS_PRE;
        PH_REF:  issue = ISS_REF;
        PH_MRS:  issue = ISS_MRS;
        PH_FIN:  issue = ISS_FIN;
        default: issue = ISS_NONE;
      endcase
    end
  end

  always_comb begin
    load     = 1'b1;
    load_val = '0;
    case (issue)
      ISS_PRE: load_val = CNT_W'(T_RP - 1);
      ISS_REF: load_val = CNT_W'(T_RC - 1);
      ISS_MRS: load_val = CNT_W'(T_MRD - 1);
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_PRE;
      ref_cnt_q <= '0;
    end else begin
      case (issue)
        ISS_PRE: phase_q <= REF_FIRST ? PH_REF : PH_MRS;
        ISS_REF: begin
          ref_cnt_q <= ref_cnt_q + 1'b1;
          if (ref_cnt_q == REF_W'(N_REF - 1)) begin
            phase_q <= REF_FIRST ? PH_MRS : PH_FIN;
          end
        end
        ISS_MRS: phase_q <= REF_FIRST ? PH_FIN : PH_REF;
        ISS_FIN: phase_q <= PH_DONE;
        default: ;
      endcase
    end
  end

  // Checker state: whether a precharge has gone out since reset
  logic pre_seen_q;
  always_ff @(posedge clk) begin
    if (rst) pre_seen_q <= 1'b0;
    else if (issue == ISS_PRE) pre_seen_q <= 1'b1;
  end

  // R3
  single_pre_chk: assert property (@(posedge clk) disable iff (rst)
    (issue == ISS_PRE) |-> !pre_seen_q);

  // R4
  ref_total_chk: assert property (@(posedge clk) disable iff (rst)
    (issue == ISS_FIN) |-> (ref_cnt_q == REF_W'(N_REF)));

  // R5
  mrs_order_chk: assert property (@(posedge clk) disable iff (rst)
    (issue == ISS_MRS) |-> (ref_cnt_q == (REF_FIRST ? REF_W'(N_REF) : REF_W'(0))));

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pre_seen_q && issue != ISS_PRE) |-> (issue == ISS_NONE));

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  issue_e            issue,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic              mem_dqm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic              init_done
);

  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  cmd_pins_t         cmd_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    case (issue)
      ISS_PRE: addr_d = AP_MASK;
      ISS_MRS: addr_d = mode_word;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= PINS_NOP;
      mem_addr  <= '0;
      mem_ba    <= '0;
      mem_cke   <= 1'b1;
      mem_dqm   <= 1'b1;
      init_done <= 1'b0;
    end else begin
      cmd_q    <= pins_for(issue);
      mem_addr <= addr_d;
      mem_ba   <= '0;
      mem_cke  <= 1'b1;
      if (issue == ISS_FIN) begin
        mem_dqm   <= 1'b0;
        init_done <= 1'b1;
      end
    end
  end

  assign mem_cs_n  = cmd_q.cs_n;
  assign mem_ras_n = cmd_q.ras_n;
  assign mem_cas_n = cmd_q.cas_n;
  assign mem_we_n  = cmd_q.we_n;

  // R7
  mrs_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == PINS_MRS) |=> (cmd_q == PINS_NOP));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd_q == PINS_NOP));

  // R2
  mask_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dqm != init_done) && mem_cke);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int PAUSE_US  = 200,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int N_REF     = 8,
  parameter bit REF_FIRST = 1'b1,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic              mem_dqm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic              init_done
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;

  issue_e issue;

  sdram_init_ctrl #(
    .PAUSE_CYC(PAUSE_CYC),
    .N_REF    (N_REF),
    .REF_FIRST(REF_FIRST),
    .T_RP     (T_RP),
    .T_RC     (T_RC),
    .T_MRD    (T_MRD)
  ) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .issue(issue)
  );

  sdram_init_pins #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .AP_BIT(AP_BIT)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .mode_word(mode_word),
    .mem_cs_n (mem_cs_n),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_cke  (mem_cke),
    .mem_dqm  (mem_dqm),
    .mem_addr (mem_addr),
    .mem_ba   (mem_ba),
    .init_done(init_done)
  );

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int CLK_MHZ  = 125;
  localparam int PAUSE_US = 2;
  localparam int P        = CLK_MHZ * PAUSE_US;
  localparam int AW       = 13;
  localparam int BW       = 2;
  localparam int APB      = 10;
  localparam int NREF     = 8;
  localparam int TRP      = 3;
  localparam int TRC      = 9;
  localparam int TMRD     = 2;

  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_MRS = 3, C_DONE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mode_word = '0;
  always #4 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done;
  logic [AW-1:0] a_addr;
  logic [BW-1:0] a_ba;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done;
  logic [AW-1:0] b_addr;
  logic [BW-1:0] b_ba;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .ADDR_W(AW), .BA_W(BW),
    .AP_BIT(APB), .N_REF(NREF), .REF_FIRST(1'b1), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD))
  u_dut (.clk(clk), .rst(rst), .mode_word(mode_word), .mem_cs_n(a_cs), .mem_ras_n(a_ras),
    .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_cke(a_cke), .mem_dqm(a_dqm), .mem_addr(a_addr),
    .mem_ba(a_ba), .init_done(a_done));

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .ADDR_W(AW), .BA_W(BW),
    .AP_BIT(APB), .N_REF(NREF), .REF_FIRST(1'b0), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD))
  u_dut_alt (.clk(clk), .rst(rst), .mode_word(mode_word), .mem_cs_n(b_cs), .mem_ras_n(b_ras),
    .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_cke(b_cke), .mem_dqm(b_dqm), .mem_addr(b_addr),
    .mem_ba(b_ba), .init_done(b_done));

  int tests  = 0;
  int fails  = 0;
  int k      = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  logic [AW-1:0] mw_edge = '0;

  // Reference schedule: command expected right after edge number k
  function automatic int exp_code(int kk, bit rf);
    int t;
    t = P;
    if (kk == t) return C_PRE;
    t += TRP;
    if (rf) begin
      for (int i = 0; i < NREF; i++) begin
        if (kk == t) return C_REF;
        t += TRC;
      end
      if (kk == t) return C_MRS;
      t += TMRD;
    end else begin
      if (kk == t) return C_MRS;
      t += TMRD;
      for (int i = 0; i < NREF; i++) begin
        if (kk == t) return C_REF;
        t += TRC;
      end
    end
    if (kk >= t) return C_DONE;
    return C_NOP;
  endfunction

  always @(posedge clk) begin
    mw_edge <= mode_word;
    started <= 1'b1;
    if (rst) k <= 0;
    else k <= k + 1;
  end

  task automatic check_one(string nm, bit rf, logic [3:0] pins, logic [AW-1:0] addr,
                           logic [BW-1:0] ba, logic cke, logic dqm, logic done);
    int c;
    logic [3:0] ep;
    logic [AW-1:0] ea;
    logic edqm, edone;
    string tag;
    c = (k == 0) ? C_NOP : exp_code(k, rf);
    ep = 4'b0111; ea = '0; edqm = 1'b1; edone = 1'b0;
    case (c)
      C_PRE:  begin ep = 4'b0010; ea = AW'(1) << APB; tag = "R3"; end
      C_REF:  begin ep = 4'b0001; tag = "R4"; end
      C_MRS:  begin ep = 4'b0000; ea = mw_edge; tag = "R6"; end
      C_DONE: begin edqm = 1'b0; edone = 1'b1; tag = "R8"; end
      default: begin
        if (k == 0) tag = "R9";
        else if (k < P) tag = "R1";
        else if (exp_code(k - 1, rf) == C_MRS) tag = "R7";
        else tag = "R4";
      end
    endcase
    tests++;
    if (pins !== ep || addr !== ea || ba !== '0 || done !== edone) begin
      fails++;
      $display("FAIL %s %s k=%0d pins=%b addr=%h ba=%0d done=%b expected pins=%b addr=%h ba=0 done=%b",
               tag, nm, k, pins, addr, ba, done, ep, ea, edone);
    end
    tests++;
    if (cke !== 1'b1 || dqm !== edqm) begin
      fails++;
      $display("FAIL R2 %s k=%0d cke=%b dqm=%b expected cke=1 dqm=%b", nm, k, cke, dqm, edqm);
    end
  endtask

  // R5: refreshes seen before the mode load, per instance
  int a_pre_ref = 0, b_pre_ref = 0;
  bit a_mrs = 1'b0, b_mrs = 1'b0, a_done_q = 1'b0, b_done_q = 1'b0;

  always @(negedge clk) begin
    if (started && !finished) begin
      check_one("u_dut", 1'b1, {a_cs, a_ras, a_cas, a_we}, a_addr, a_ba, a_cke, a_dqm, a_done);
      check_one("u_dut_alt", 1'b0, {b_cs, b_ras, b_cas, b_we}, b_addr, b_ba, b_cke, b_dqm, b_done);
      if (k == 0) begin
        a_pre_ref = 0; b_pre_ref = 0; a_mrs = 0; b_mrs = 0; a_done_q = 0; b_done_q = 0;
      end else begin
        if ({a_cs, a_ras, a_cas, a_we} == 4'b0000) a_mrs = 1;
        if ({b_cs, b_ras, b_cas, b_we} == 4'b0000) b_mrs = 1;
        if ({a_cs, a_ras, a_cas, a_we} == 4'b0001 && !a_mrs) a_pre_ref++;
        if ({b_cs, b_ras, b_cas, b_we} == 4'b0001 && !b_mrs) b_pre_ref++;
        if (a_done && !a_done_q) begin
          tests++;
          if (a_pre_ref != NREF) begin
            fails++;
            $display("FAIL R5 u_dut refreshes before mode load=%0d expected %0d", a_pre_ref, NREF);
          end
        end
        if (b_done && !b_done_q) begin
          tests++;
          if (b_pre_ref != 0) begin
            fails++;
            $display("FAIL R5 u_dut_alt refreshes before mode load=%0d expected 0", b_pre_ref);
          end
        end
        a_done_q = a_done; b_done_q = b_done;
      end
      mode_word <= AW'($urandom);
    end
  end

  localparam int FULL = P + TRP + NREF * TRC + TMRD + 20;

  task automatic run_to(int target);
    while (k < target) @(negedge clk);
  endtask

  task automatic do_reset(int n);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_to(FULL);                               // R1..R8 full sequence, both orders
    do_reset(2);                                // R9 reset after completion
    run_to(P + TRP + 3 * TRC + 2);              // inside refresh train of u_dut
    do_reset(3);                                // R9 reset mid-sequence
    run_to(P + TRP + 1);                        // just after mode load of u_dut_alt
    do_reset(1);                                // R9 reset right after mode load
    run_to(FULL);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1'b1;
    tests++;
    fails++;
    $display("FAIL watchdog expired k=%0d expected completion", k);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule